// File: doc/BRIEF.md
# Chained Bus Watchpoint Comparator Pair

This block watches every bus cycle of a processor core with two programmable watchpoint units, here called unit 0 and unit 1. Each unit holds an address value and mask, a data value and mask, and a control value and mask. A unit matches when every bit left unmasked in those three fields agrees with the current cycle. The control field covers the transfer direction, the access size, the fetch-or-data kind, the privilege level, one external condition line per unit, and two coupling inputs. When a unit's arm bit is set, its match raises that unit's hit output.

Unit 1 can qualify unit 0 in two ways. Its address comparison drives unit 0's span input in the same cycle, so that unit 0 can require both address windows to hold at once. Its link latch drives unit 0's link input. The latch samples unit 1's data comparison on every clock edge where unit 1's address and control comparisons both pass. This allows conditions such as "stop on this address, but only after that data value was seen at that other address". Registers are loaded through a plain synchronous write port: a write enable, a register select and a write data word.

Top module: `bus_watch_pair`

## Requirements
- R1: While the active-low reset `rstN` is low, and after it is released, all value and mask registers hold zero, both hit outputs are low and the link latch is clear.
- R2: The address field passes when every address bit whose mask bit is 0 equals the stored address value bit. A mask bit of 1 excludes that bit from the comparison.
- R3: The data field passes when every data bit whose mask bit is 0 equals the stored data value bit. A mask bit of 1 excludes that bit from the comparison.
- R4: The control value and mask hold the observed cycle attributes at these positions: bit 0 is the direction (`busWrite`, 1 = write, 0 = read); bits 2:1 are the size (`busSize`, 00 byte, 01 halfword, 10 word, 11 reserved); bit 3 is the kind (`busIsData`, 0 = instruction fetch, 1 = data); bit 4 is the privilege (`busPriv`, 0 = user, 1 = privileged); and bit 5 is the unit's own `extCond` line. Each bit with a mask bit of 0 must equal the stored value bit.
- R5: Bit 8 of the control value is the arm bit. `hit[n]` is 1 only when unit n's arm bit is 1 and its address, data and control fields all pass. Bit 8 written to a control mask has no effect.
- R6: On each rising clock edge where unit 1's address and control fields both pass, its link latch takes unit 1's data-field result. On any other edge the latch keeps its value.
- R7: A write to unit 1's control value register clears the link latch on that edge. This takes priority over a capture on the same edge.
- R8: Control bit 6 of unit 0 is compared with unit 1's link latch. Control bit 7 of unit 0 is compared with unit 1's address-field result in the same cycle. For unit 1, both of these observed bits are 0.
- R9: `regSel[3]` picks the unit. `regSel[2:0]` picks the register: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value (9 bits), 5 control mask (8 bits). Codes 6 and 7 change nothing.
- R10: A register write takes effect from the clock edge where `regWe` is high. The hit outputs follow the bus inputs combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regSel | input | 4 | Unit (bit 3) and register index (bits 2:0) |
| regWdata | input | 32 | Register write data |
| busAddr | input | 32 | Address of the current bus cycle |
| busData | input | 32 | Data of the current bus cycle |
| busWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| busSize | input | 2 | Access size code |
| busIsData | input | 1 | 1 = data access, 0 = instruction fetch |
| busPriv | input | 1 | 1 = privileged, 0 = user |
| extCond | input | 2 | External condition, one bit per unit |
| hit | output | 2 | Watchpoint hit, one bit per unit |

## Verification
Directed patterns are run first. Addresses inside and just outside a masked window tell masked bits apart from compared ones, and each control attribute is flipped alone against a fully specified control value to show that each bit position is decoded on its own. A chain sequence then shows when the link latch captures, when it holds and when it is cleared. It separates a capture that found the data value from one that did not, and it tests a clear that lands on the same edge as a capture. A random phase mixes bus cycles aimed at the programmed addresses with random writes to every register code, including the unused ones, and with a reset in the middle of the run. A cycle-level model in the bench checks every cycle of this phase.

// File: rtl/bus_watch_pkg.sv
package bus_watch_pkg;
  localparam int NUM_WP_DEF = 2;
  localparam int ADDR_W_DEF = 32;
  localparam int DATA_W_DEF = 32;
  localparam int CTL_W      = 8;   // compared control bits
  localparam int ARM_BIT    = 8;   // non-maskable arm bit of control value
  localparam int IDX_W      = 3;   // register index width within a unit

  // control field bit positions (R4, R8)
  localparam int CB_DIR  = 0;
  localparam int CB_SIZE = 1;
  localparam int CB_KIND = 3;
  localparam int CB_PRIV = 4;
  localparam int CB_EXT  = 5;
  localparam int CB_LINK = 6;
  localparam int CB_SPAN = 7;

  typedef enum logic [IDX_W-1:0] {
    SEL_ADDR_VAL = 3'd0,
    SEL_ADDR_MSK = 3'd1,
    SEL_DATA_VAL = 3'd2,
    SEL_DATA_MSK = 3'd3,
    SEL_CTL_VAL  = 3'd4,
    SEL_CTL_MSK  = 3'd5
  } regIdx_e;

  typedef struct packed {
    logic addrVal;
    logic addrMsk;
    logic dataVal;
    logic dataMsk;
    logic ctlVal;
    logic ctlMsk;
  } wpStrobe_t;
endpackage

// File: rtl/bus_watch_ctrl.sv
module bus_watch_ctrl
  import bus_watch_pkg::*;
#(
  parameter int NUM_WP   = NUM_WP_DEF,
  parameter int WP_SEL_W = 1,
  localparam int SEL_W   = WP_SEL_W + IDX_W
) (
  input  logic                   regWe,
  input  logic [SEL_W-1:0]       regSel,
  output wpStrobe_t [NUM_WP-1:0] strobe
);
  // R9: decode unit and register index into per-unit write strobes
  logic [WP_SEL_W-1:0] unitSel;
  regIdx_e             regIdx;

  assign unitSel = regSel[SEL_W-1:IDX_W];
  assign regIdx  = regIdx_e'(regSel[IDX_W-1:0]);

  always_comb begin
    for (int i = 0; i < NUM_WP; i++) begin
      strobe[i] = '0;
      if (regWe && unitSel == WP_SEL_W'(i)) begin
        unique case (regIdx)
          SEL_ADDR_VAL: strobe[i].addrVal = 1'b1;
          SEL_ADDR_MSK: strobe[i].addrMsk = 1'b1;
          SEL_DATA_VAL: strobe[i].dataVal = 1'b1;
          SEL_DATA_MSK: strobe[i].dataMsk = 1'b1;
          SEL_CTL_VAL:  strobe[i].ctlVal  = 1'b1;
          SEL_CTL_MSK:  strobe[i].ctlMsk  = 1'b1;
          default:      strobe[i] = '0;   // codes 6 and 7 write nothing
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_watch_dp.sv
module bus_watch_dp
  import bus_watch_pkg::*;
#(
  parameter int NUM_WP  = NUM_WP_DEF,
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int WDATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wpStrobe_t [NUM_WP-1:0] strobe,
  input  logic [WDATA_W-1:0]     regWdata,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busData,
  input  logic                   busWrite,
  input  logic [1:0]             busSize,
  input  logic                   busIsData,
  input  logic                   busPriv,
  input  logic [NUM_WP-1:0]      extCond,
  output logic [NUM_WP-1:0]      hit,
  output logic [NUM_WP-1:0]      armVec,
  output logic [NUM_WP-1:0]      capEn,
  output logic [NUM_WP-1:0]      dataOkVec,
  output logic [NUM_WP-1:0]      linkQ,
  output logic [NUM_WP-1:0]      spanVec
);
  for (genvar g = 0; g < NUM_WP; g++) begin : gUnit
    logic [ADDR_W-1:0]  addrVal, addrMsk;
    logic [DATA_W-1:0]  dataVal, dataMsk;
    logic [ARM_BIT:0]   ctlVal;
    logic [CTL_W-1:0]   ctlMsk;
    logic [CTL_W-1:0]   observed;
    logic               linkIn, spanIn;
    logic               addrOk, dataOk, ctlOk;
    logic               linkReg;

    // R1, R9, R10: register bank of this unit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrVal <= '0;
        addrMsk <= '0;
        dataVal <= '0;
        dataMsk <= '0;
        ctlVal  <= '0;
        ctlMsk  <= '0;
      end else begin
        if (strobe[g].addrVal) addrVal <= regWdata[ADDR_W-1:0];
        if (strobe[g].addrMsk) addrMsk <= regWdata[ADDR_W-1:0];
        if (strobe[g].dataVal) dataVal <= regWdata[DATA_W-1:0];
        if (strobe[g].dataMsk) dataMsk <= regWdata[DATA_W-1:0];
        if (strobe[g].ctlVal)  ctlVal  <= regWdata[ARM_BIT:0];
        if (strobe[g].ctlMsk)  ctlMsk  <= regWdata[CTL_W-1:0];  // R5: no mask for arm bit
      end
    end

    // R8: coupling from the next-higher unit; the last unit sees zeros
    if (g < NUM_WP - 1) begin : gCoupled
      assign linkIn = linkQ[g+1];
      assign spanIn = spanVec[g+1];
    end else begin : gTail
      assign linkIn = 1'b0;
      assign spanIn = 1'b0;
    end

    // R4: observed cycle attributes in control-field layout
    always_comb begin
      observed                   = '0;
      observed[CB_DIR]           = busWrite;
      observed[CB_SIZE+1:CB_SIZE] = busSize;
      observed[CB_KIND]          = busIsData;
      observed[CB_PRIV]          = busPriv;
      observed[CB_EXT]           = extCond[g];
      observed[CB_LINK]          = linkIn;
      observed[CB_SPAN]          = spanIn;
    end

    // R2, R3, R4: masked equality, mask bit 1 = don't care
    assign addrOk = &((busAddr ~^ addrVal) | addrMsk);
    assign dataOk = &((busData ~^ dataVal) | dataMsk);
    assign ctlOk  = &((observed ~^ ctlVal[CTL_W-1:0]) | ctlMsk);

    // R6, R7: link latch, clear beats capture
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               linkReg <= 1'b0;
      else if (strobe[g].ctlVal) linkReg <= 1'b0;
      else if (addrOk && ctlOk)  linkReg <= dataOk;
    end

    // R5: hit gated by arm bit
    assign hit[g]       = ctlVal[ARM_BIT] & addrOk & dataOk & ctlOk;
    assign armVec[g]    = ctlVal[ARM_BIT];
    assign capEn[g]     = addrOk & ctlOk;
    assign dataOkVec[g] = dataOk;
    assign linkQ[g]     = linkReg;
    assign spanVec[g]   = addrOk;
  end
endmodule

// File: rtl/bus_watch_pair.sv
module bus_watch_pair
  import bus_watch_pkg::*;
#(
  parameter int NUM_WP   = NUM_WP_DEF,
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int DATA_W   = DATA_W_DEF,
  localparam int WP_SEL_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
  localparam int SEL_W    = WP_SEL_W + IDX_W,
  localparam int WDATA_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [WDATA_W-1:0] regWdata,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  input  logic               busWrite,
  input  logic [1:0]         busSize,
  input  logic               busIsData,
  input  logic               busPriv,
  input  logic [NUM_WP-1:0]  extCond,
  output logic [NUM_WP-1:0]  hit
);
  wpStrobe_t [NUM_WP-1:0] strobe;
  logic [NUM_WP-1:0] armVec, capEn, dataOkVec, linkQ, spanVec;

  bus_watch_ctrl #(.NUM_WP(NUM_WP), .WP_SEL_W(WP_SEL_W)) u_ctrl (
    .regWe  (regWe),
    .regSel (regSel),
    .strobe (strobe)
  );

  bus_watch_dp #(
    .NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WDATA_W(WDATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWdata  (regWdata),
    .busAddr   (busAddr),
    .busData   (busData),
    .busWrite  (busWrite),
    .busSize   (busSize),
    .busIsData (busIsData),
    .busPriv   (busPriv),
    .extCond   (extCond),
    .hit       (hit),
    .armVec    (armVec),
    .capEn     (capEn),
    .dataOkVec (dataOkVec),
    .linkQ     (linkQ),
    .spanVec   (spanVec)
  );
endmodule

// File: rtl/bus_watch_pair_chk.sv
module bus_watch_pair_chk #(
  parameter int NUM_WP   = 2,
  parameter int WP_SEL_W = 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [WP_SEL_W+2:0]   regSel,
  input logic [NUM_WP-1:0]     hit,
  input logic [NUM_WP-1:0]     armVec,
  input logic [NUM_WP-1:0]     capEn,
  input logic [NUM_WP-1:0]     dataOkVec,
  input logic [NUM_WP-1:0]     linkQ,
  input logic [NUM_WP-1:0]     spanVec
);
  logic [NUM_WP-1:0] ctlWr;
  always_comb begin
    for (int i = 0; i < NUM_WP; i++)
      ctlWr[i] = regWe && (regSel[WP_SEL_W+2:3] == WP_SEL_W'(i)) && (regSel[2:0] == 3'd4);
  end

  AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (hit & ~armVec) == '0);  // R5

  for (genvar i = 0; i < NUM_WP; i++) begin : gChk
    AST_LINK_CLEAR_ON_CTL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      ctlWr[i] |=> !linkQ[i]);  // R7
    AST_LINK_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      (capEn[i] && !ctlWr[i]) |=> (linkQ[i] == $past(dataOkVec[i])));  // R6
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!capEn[i] && !ctlWr[i]) |=> $stable(linkQ[i]));  // R6
    AST_HIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
      hit[i] |-> dataOkVec[i]);  // R3
  end

  AST_SPAN_UNUSED_ON_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    capEn[NUM_WP-1] |-> spanVec[NUM_WP-1]);  // R8
endmodule

bind bus_watch_pair bus_watch_pair_chk #(.NUM_WP(NUM_WP), .WP_SEL_W(WP_SEL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWe     (regWe),
  .regSel    (regSel),
  .hit       (hit),
  .armVec    (armVec),
  .capEn     (capEn),
  .dataOkVec (dataOkVec),
  .linkQ     (linkQ),
  .spanVec   (spanVec)
);

// File: tb/bus_watch_pair_bench.sv
`timescale 1ns/1ps
module bus_watch_pair_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [3:0]  regSel;
  logic [31:0] regWdata;
  logic [31:0] busAddr, busData;
  logic        busWrite, busIsData, busPriv;
  logic [1:0]  busSize;
  logic [1:0]  extCond;
  logic [1:0]  hit;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_watch_pair u_bus_watch_pair (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busAddr(busAddr), .busData(busData), .busWrite(busWrite), .busSize(busSize),
    .busIsData(busIsData), .busPriv(busPriv), .extCond(extCond), .hit(hit)
  );

  // reference model state
  logic [31:0] mAV [2];
  logic [31:0] mAM [2];
  logic [31:0] mDV [2];
  logic [31:0] mDM [2];
  logic [8:0]  mCV [2];
  logic [7:0]  mCM [2];
  logic        mLink;

  task automatic resetModel();
    for (int w = 0; w < 2; w++) begin
      mAV[w] = 0; mAM[w] = 0; mDV[w] = 0; mDM[w] = 0; mCV[w] = 0; mCM[w] = 0;
    end
    mLink = 1'b0;
  endtask

  function automatic logic wordAgrees(logic [31:0] v, logic [31:0] m, logic [31:0] b);
    for (int k = 0; k < 32; k++)
      if (!m[k] && (v[k] !== b[k])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic addrAgrees(int w);
    return wordAgrees(mAV[w], mAM[w], busAddr);
  endfunction

  function automatic logic dataAgrees(int w);
    return wordAgrees(mDV[w], mDM[w], busData);
  endfunction

  function automatic logic ctlAgrees(int w);
    logic [7:0] seen;
    seen[0]   = busWrite;
    seen[2:1] = busSize;
    seen[3]   = busIsData;
    seen[4]   = busPriv;
    seen[5]   = extCond[w];
    seen[6]   = (w == 0) ? mLink : 1'b0;
    seen[7]   = (w == 0) ? addrAgrees(1) : 1'b0;
    for (int k = 0; k < 8; k++)
      if (!mCM[w][k] && (seen[k] !== mCV[w][k])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [1:0] expectHit();
    logic [1:0] e;
    for (int w = 0; w < 2; w++)
      e[w] = mCV[w][8] && addrAgrees(w) && dataAgrees(w) && ctlAgrees(w);
    return e;
  endfunction

  // compare in the middle of the low phase, then advance one clock
  task automatic step(string req);
    logic [1:0] e;
    logic cap, capVal;
    int w;
    #1;
    if (!rstN) resetModel();
    e = expectHit();
    checks++;
    if (hit !== e) begin
      fails++;
      $display("FAIL %s: hit actual=%b expected=%b at %0t", req, hit, e, $time);
    end
    @(posedge clk);
    if (!rstN) begin
      resetModel();
    end else begin
      cap    = addrAgrees(1) && ctlAgrees(1);
      capVal = dataAgrees(1);
      if (regWe) begin
        w = regSel[3];
        case (regSel[2:0])
          3'd0: mAV[w] = regWdata;
          3'd1: mAM[w] = regWdata;
          3'd2: mDV[w] = regWdata;
          3'd3: mDM[w] = regWdata;
          3'd4: mCV[w] = regWdata[8:0];
          3'd5: mCM[w] = regWdata[7:0];
          default: ;
        endcase
      end
      if (regWe && regSel == 4'b1100) mLink = 1'b0;
      else if (cap) mLink = capVal;
    end
    @(negedge clk);
  endtask

  task automatic wr(int w, int idx, logic [31:0] v, string req);
    regWe    = 1'b1;
    regSel   = {w[0], idx[2:0]};
    regWdata = v;
    step(req);
    regWe    = 1'b0;
  endtask

  task automatic setBus(logic [31:0] a, logic [31:0] d, logic wrt, logic [1:0] sz,
                        logic isD, logic pv, logic [1:0] ext);
    busAddr = a; busData = d; busWrite = wrt; busSize = sz;
    busIsData = isD; busPriv = pv; extCond = ext;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    resetModel();
    rstN = 1'b0; regWe = 1'b0; regSel = '0; regWdata = '0;
    setBus(32'h0, 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    step("R1");
    step("R1");
    rstN = 1'b1;
    step("R1");

    // R9, R2: unit 1 address window 0x1000..0x100F, data and control ignored
    wr(1, 0, 32'h0000_1000, "R9");
    wr(1, 1, 32'h0000_000F, "R9");
    wr(1, 3, 32'hFFFF_FFFF, "R9");
    wr(1, 5, 32'h0000_00FF, "R9");
    wr(1, 4, 32'h0000_0100, "R10");
    setBus(32'h0000_1005, 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
    step("R2");
    busAddr = 32'h0000_1015;
    step("R2");
    busAddr = 32'h0000_100F;
    step("R2");

    // R3: data high half compared
    wr(1, 3, 32'h0000_FFFF, "R3");
    wr(1, 2, 32'hCAFE_0000, "R3");
    busData = 32'hCAFE_1234;
    step("R3");
    busData = 32'hCAFF_1234;
    step("R3");

    // R4: write, word, data, privileged, ext=1; each field flipped alone
    busData = 32'hCAFE_0000;
    wr(1, 5, 32'h0000_00C0, "R4");
    wr(1, 4, 32'h0000_013D, "R4");
    setBus(32'h0000_1001, 32'hCAFE_0000, 1'b1, 2'b10, 1'b1, 1'b1, 2'b10);
    step("R4");
    busWrite = 1'b0;     step("R4"); busWrite = 1'b1;
    busSize = 2'b11;     step("R4"); busSize = 2'b00; step("R4"); busSize = 2'b10;
    busIsData = 1'b0;    step("R4"); busIsData = 1'b1;
    busPriv = 1'b0;      step("R4"); busPriv = 1'b1;
    extCond = 2'b01;     step("R4"); extCond = 2'b10;
    step("R4");

    // R5: mask bit 8 written, arm cleared -> no hit; rearm -> hit
    wr(1, 5, 32'h0000_01FF, "R5");
    wr(1, 4, 32'h0000_003D, "R5");
    step("R5");
    wr(1, 4, 32'h0000_013D, "R5");
    step("R5");

    // R6, R7, R8: link from unit 1 to unit 0
    wr(1, 0, 32'h0000_2000, "R6");
    wr(1, 1, 32'h0000_0000, "R6");
    wr(1, 2, 32'h0000_0055, "R6");
    wr(1, 3, 32'hFFFF_FF00, "R6");
    wr(1, 5, 32'h0000_00FF, "R6");
    wr(0, 1, 32'hFFFF_FFFF, "R8");
    wr(0, 3, 32'hFFFF_FFFF, "R8");
    wr(0, 5, 32'h0000_00BF, "R8");
    wr(0, 4, 32'h0000_0140, "R8");
    setBus(32'h0000_3000, 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
    wr(1, 4, 32'h0000_0000, "R7");
    step("R7");                        // latch clear, unit 0 quiet
    setBus(32'h0000_2000, 32'h0000_0055, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
    step("R8");                        // captures 1 at this edge
    step("R6");                        // unit 0 hits
    setBus(32'h0000_3000, 32'h0000_0000, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
    step("R6");                        // hold
    step("R6");
    setBus(32'h0000_2000, 32'h0000_0066, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00);
    step("R6");                        // captures 0
    step("R6");
    busData = 32'h0000_0055;
    step("R6");                        // captures 1
    wr(1, 4, 32'h0000_0000, "R7");     // clear beats capture
    busAddr = 32'h0000_3000;
    step("R7");
    step("R7");

    // R8: span coupling, unit 0 compares only bit 7
    wr(0, 5, 32'h0000_007F, "R8");
    wr(0, 4, 32'h0000_0180, "R8");
    busAddr = 32'h0000_2000; step("R8");
    busAddr = 32'h0000_2001; step("R8");

    // R9: unused register codes
    wr(0, 6, 32'hFFFF_FFFF, "R9");
    wr(1, 7, 32'h0000_0000, "R9");
    busAddr = 32'h0000_2000; step("R9");

    // random phase, model compared every cycle
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      case (r[1:0])
        2'd0: busAddr = 32'h0000_2000;
        2'd1: busAddr = 32'h0000_1005;
        2'd2: busAddr = {28'h0000_100, r[7:4]};
        default: busAddr = $urandom;
      endcase
      busData   = r[8] ? 32'h0000_0055 : {24'h0, r[23:16]};
      busWrite  = r[9];
      busSize   = r[11:10];
      busIsData = r[12];
      busPriv   = r[13];
      extCond   = r[15:14];
      if (n == 300) rstN = 1'b0;
      if (n == 302) rstN = 1'b1;
      if (r[31:29] == 3'd0 && rstN) begin
        logic [31:0] v;
        v = $urandom;
        if (r[26:24] == 3'd1 || r[26:24] == 3'd3) v = r[27] ? 32'hFFFF_FF00 : 32'h0000_000F;
        if (r[26:24] == 3'd0) v = r[27] ? 32'h0000_2000 : 32'h0000_1000;
        if (r[26:24] == 3'd5) v = {24'h0, 2'b11, r[5:0] & 6'h3F};
        wr(int'(r[28]), int'(r[26:24]), v, "R10");
      end else begin
        step(n >= 300 && n < 304 ? "R1" : "R10");
      end
    end

    finishRun();
  end
endmodule